// File: doc/BRIEF.md
# Serial Memory Write-Protect Gate

This block decides whether a decoded write command may change a small serial memory. The command decoder presents a one-cycle strobe for an array write or a status-register write. The gate answers in the same cycle with an allow or a refuse signal for that command. The surrounding logic only commits the write when the allow signal is high.

Three things are combined for each command:
- the two block-protect bits held in the status register;
- the active-low write-protect pin;
- the state of the write-enable latch.

The protected region sits at the top of the array. It covers a quarter, a half or all of the array, and is scaled to the array size selected by a size flag (256 or 512 bytes).

While the pin is low, the gate also drives a registered clear request so that the write-enable latch is held in its reset state.

Top module: `spi_wp_gate`

## Requirements
- R1: With protect code 00 (`bp_code`), an array write is accepted at every address, for both sizes, when the pin is high and the latch is set.
- R2: Code 01 refuses array writes in the upper quarter: 0x180–0x1FF for the 512-byte size and 0xC0–0xFF for the 256-byte size. Addresses below these ranges are accepted.
- R3: Code 10 refuses array writes in the upper half: 0x100–0x1FF for the 512-byte size and 0x80–0xFF for the 256-byte size. Addresses below these ranges are accepted.
- R4: Code 11 refuses array writes at every address of either size.
- R5: For the 256-byte size (`size_large` = 0), address bit 8 has no effect on the decision. Only bits 7:0 are compared.
- R6: While `wp_n` is 0, both array writes and status writes are refused.
- R7: While `wel` is 0, both array writes and status writes are refused, whatever the protect code.
- R8: Each allow/refuse output is combinational and is high only in a cycle where its strobe is high. For a strobed command, exactly one of allow and refuse is high.
- R9: `wel_clr` is 0 while in reset. It is 1 in the cycle after a clock edge that sampled `wp_n` at 0, and 0 in the cycle after an edge that sampled `wp_n` at 1.
- R10: A status write does not depend on the protect code or the address. It is accepted whenever the pin is high and the latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp_code | input | 2 | Block-protect code from the status register |
| wp_n | input | 1 | Write-protect pin, active low |
| size_large | input | 1 | 1 selects the 512-byte array, 0 selects the 256-byte array |
| wel | input | 1 | Current write-enable latch state |
| addr | input | 9 | Target byte address of the array write |
| arr_wr_stb | input | 1 | Array write command strobe |
| sr_wr_stb | input | 1 | Status-register write command strobe |
| arr_wr_ok | output | 1 | Array write allowed |
| arr_wr_blocked | output | 1 | Array write refused |
| sr_wr_ok | output | 1 | Status write allowed |
| sr_wr_blocked | output | 1 | Status write refused |
| wel_clr | output | 1 | Registered request to hold the write-enable latch clear |

## Verification
The bench builds the gate with its default 9-bit address width. This is the width where both array sizes are reachable and the 256-byte size has a real ignored bit 8.

A vector table first covers the first and last address on each side of every region boundary, for both sizes. It also covers addresses with bit 8 set under the small size, and the pin and latch refusals.

A computed sweep then crosses all four protect codes with both sizes and fifteen boundary addresses. Directed steps follow the registered latch-clear request through reset, through the pin falling and through the pin rising.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_code_e;
endpackage

// File: rtl/wpg_rst_sync.sv
module wpg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wpg_region_cmp.sv
module wpg_region_cmp
  import wpg_pkg::*;
(
  input  prot_code_e  code,
  input  logic        size_large,
  input  logic [2:0]  addr_hi,   // address bits 8:6
  output logic        hit
);
  logic [1:0] top;

  always_comb begin
    // Large array compares bits 8:7; small array compares bits 7:6 and drops bit 8
    top = size_large ? addr_hi[2:1] : addr_hi[1:0];
    unique case (code)
      PROT_NONE:    hit = 1'b0;
      PROT_QUARTER: hit = (top == 2'b11);
      PROT_HALF:    hit = top[1];
      PROT_ALL:     hit = 1'b1;
      default:      hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpg_cmd_gate.sv
module wpg_cmd_gate #(
  parameter bit USE_REGION = 1'b1
) (
  input  logic stb,
  input  logic wp_n,
  input  logic wel,
  input  logic region_hit,
  output logic ok,
  output logic blocked
);
  logic permit;

  generate
    if (USE_REGION) begin : g_region
      always_comb permit = wp_n & wel & ~region_hit;
    end else begin : g_plain
      logic unused_hit;
      assign unused_hit = region_hit;
      always_comb permit = wp_n & wel;
    end
  endgenerate

  always_comb begin
    ok      = stb & permit;
    blocked = stb & ~permit;
  end
endmodule

// File: rtl/wpg_wel_clr.sv
module wpg_wel_clr (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n,
  output logic clr
);
  logic clr_d;
  logic clr_q;

  always_comb begin
    clr_d = ~wp_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= clr_d;
  end

  assign clr = clr_q;
endmodule

// File: rtl/spi_wp_gate.sv
module spi_wp_gate
  import wpg_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bp_code,
  input  logic              wp_n,
  input  logic              size_large,
  input  logic              wel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              arr_wr_stb,
  input  logic              sr_wr_stb,
  output logic              arr_wr_ok,
  output logic              arr_wr_blocked,
  output logic              sr_wr_ok,
  output logic              sr_wr_blocked,
  output logic              wel_clr
);
  localparam int HI_LSB = ADDR_W - 3;

  logic       rst_sync_n;
  logic       region_hit;
  logic [2:0] addr_hi;
  logic [HI_LSB-1:0] unused_addr_lo;

  assign addr_hi        = addr[ADDR_W-1:HI_LSB];
  assign unused_addr_lo = addr[HI_LSB-1:0];

  wpg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wpg_region_cmp u_region (
    .code       (prot_code_e'(bp_code)),
    .size_large (size_large),
    .addr_hi    (addr_hi),
    .hit        (region_hit)
  );

  wpg_cmd_gate #(.USE_REGION(1'b1)) u_arr_gate (
    .stb        (arr_wr_stb),
    .wp_n       (wp_n),
    .wel        (wel),
    .region_hit (region_hit),
    .ok         (arr_wr_ok),
    .blocked    (arr_wr_blocked)
  );

  wpg_cmd_gate #(.USE_REGION(1'b0)) u_sr_gate (
    .stb        (sr_wr_stb),
    .wp_n       (wp_n),
    .wel        (wel),
    .region_hit (region_hit),
    .ok         (sr_wr_ok),
    .blocked    (sr_wr_blocked)
  );

  wpg_wel_clr u_clr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wp_n  (wp_n),
    .clr   (wel_clr)
  );
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker (
  input logic       clk,
  input logic       rst_q_n,
  input logic [1:0] bp_code,
  input logic       wp_n,
  input logic       wel,
  input logic       arr_wr_stb,
  input logic       sr_wr_stb,
  input logic       arr_wr_ok,
  input logic       arr_wr_blocked,
  input logic       sr_wr_ok,
  input logic       sr_wr_blocked,
  input logic       wel_clr
);
  AST_OPEN_CODE_ALLOWS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bp_code == 2'b00 && wp_n && wel && arr_wr_stb) |-> arr_wr_ok); // R1
  AST_WHOLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bp_code == 2'b11) |-> !arr_wr_ok); // R4
  AST_PIN_REFUSES: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wp_n |-> (!arr_wr_ok && !sr_wr_ok)); // R6
  AST_LATCH_REFUSES: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wel |-> (!arr_wr_ok && !sr_wr_ok)); // R7
  AST_ARR_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_q_n)
    arr_wr_stb |-> $onehot({arr_wr_ok, arr_wr_blocked})); // R8
  AST_SR_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_q_n)
    sr_wr_stb |-> $onehot({sr_wr_ok, sr_wr_blocked})); // R8
  AST_QUIET_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!arr_wr_stb && !sr_wr_stb) |->
      ($countones({arr_wr_ok, arr_wr_blocked, sr_wr_ok, sr_wr_blocked}) == 0)); // R8
  AST_CLR_FOLLOWS_LOW: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wp_n |=> wel_clr); // R9
  AST_CLR_FOLLOWS_HIGH: assert property (@(posedge clk) disable iff (!rst_q_n)
    wp_n |=> !wel_clr); // R9
  AST_SR_OPEN: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sr_wr_stb && wp_n && wel) |-> sr_wr_ok); // R10
endmodule

bind spi_wp_gate wpg_checker u_wpg_checker (
  .clk            (clk),
  .rst_q_n        (rst_sync_n),
  .bp_code        (bp_code),
  .wp_n           (wp_n),
  .wel            (wel),
  .arr_wr_stb     (arr_wr_stb),
  .sr_wr_stb      (sr_wr_stb),
  .arr_wr_ok      (arr_wr_ok),
  .arr_wr_blocked (arr_wr_blocked),
  .sr_wr_ok       (sr_wr_ok),
  .sr_wr_blocked  (sr_wr_blocked),
  .wel_clr        (wel_clr)
);

// File: tb/test_spi_wp_gate.sv
module test_spi_wp_gate;
  logic       clk;
  logic       rst_n;
  logic [1:0] bp_code;
  logic       wp_n;
  logic       size_large;
  logic       wel;
  logic [8:0] addr;
  logic       arr_wr_stb;
  logic       sr_wr_stb;
  logic       arr_wr_ok;
  logic       arr_wr_blocked;
  logic       sr_wr_ok;
  logic       sr_wr_blocked;
  logic       wel_clr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  spi_wp_gate i_spi_wp_gate (
    .clk(clk), .rst_n(rst_n), .bp_code(bp_code), .wp_n(wp_n),
    .size_large(size_large), .wel(wel), .addr(addr),
    .arr_wr_stb(arr_wr_stb), .sr_wr_stb(sr_wr_stb),
    .arr_wr_ok(arr_wr_ok), .arr_wr_blocked(arr_wr_blocked),
    .sr_wr_ok(sr_wr_ok), .sr_wr_blocked(sr_wr_blocked), .wel_clr(wel_clr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector: {req[3:0], bp[1:0], large, addr[8:0], wp_n, wel, arr, sr, exp{aok,ablk,sok,sblk}}
  localparam int NV = 18;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1,  2'b00, 1'b1, 9'h1FF, 4'b1110, 4'b1000}, // R1
    {4'd1,  2'b00, 1'b0, 9'h0FF, 4'b1110, 4'b1000}, // R1
    {4'd2,  2'b01, 1'b1, 9'h17F, 4'b1110, 4'b1000}, // R2
    {4'd2,  2'b01, 1'b1, 9'h180, 4'b1110, 4'b0100}, // R2
    {4'd2,  2'b01, 1'b0, 9'h0BF, 4'b1110, 4'b1000}, // R2
    {4'd2,  2'b01, 1'b0, 9'h0C0, 4'b1110, 4'b0100}, // R2
    {4'd3,  2'b10, 1'b1, 9'h0FF, 4'b1110, 4'b1000}, // R3
    {4'd3,  2'b10, 1'b1, 9'h100, 4'b1110, 4'b0100}, // R3
    {4'd3,  2'b10, 1'b0, 9'h07F, 4'b1110, 4'b1000}, // R3
    {4'd3,  2'b10, 1'b0, 9'h080, 4'b1110, 4'b0100}, // R3
    {4'd4,  2'b11, 1'b1, 9'h000, 4'b1110, 4'b0100}, // R4
    {4'd4,  2'b11, 1'b0, 9'h000, 4'b1110, 4'b0100}, // R4
    {4'd5,  2'b01, 1'b0, 9'h1BF, 4'b1110, 4'b1000}, // R5
    {4'd5,  2'b10, 1'b0, 9'h17F, 4'b1110, 4'b1000}, // R5
    {4'd6,  2'b00, 1'b1, 9'h000, 4'b0111, 4'b0101}, // R6
    {4'd7,  2'b00, 1'b1, 9'h000, 4'b1011, 4'b0101}, // R7
    {4'd10, 2'b11, 1'b1, 9'h1FF, 4'b1101, 4'b0010}, // R10
    {4'd8,  2'b00, 1'b1, 9'h000, 4'b1100, 4'b0000}  // R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] b, input logic lg, input logic [8:0] a,
                       input logic [3:0] ctl);
    @(negedge clk);
    bp_code = b; size_large = lg; addr = a;
    {wp_n, wel, arr_wr_stb, sr_wr_stb} = ctl;
    #2;
  endtask

  function automatic logic model_prot(input logic [1:0] b, input logic lg, input logic [8:0] a);
    logic [1:0] t;
    t = lg ? a[8:7] : a[7:6];
    return (b == 2'b11) || (b == 2'b10 && t[1]) || (b == 2'b01 && t == 2'b11);
  endfunction

  function automatic void summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endfunction

  initial begin
    #1_500_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  localparam logic [8:0] EDGES [15] = '{9'h000, 9'h03F, 9'h040, 9'h07F, 9'h080,
    9'h0BF, 9'h0C0, 9'h0FF, 9'h100, 9'h13F, 9'h17F, 9'h180, 9'h1BF, 9'h1C0, 9'h1FF};

  initial begin
    rst_n = 1'b0; bp_code = 2'b00; wp_n = 1'b1; size_large = 1'b1;
    wel = 1'b1; addr = '0; arr_wr_stb = 1'b0; sr_wr_stb = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R9 reset state", {31'd0, wel_clr}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19:18], VEC[i][17], VEC[i][16:8], VEC[i][7:4]);
      check($sformatf("R%0d vector %0d", VEC[i][23:20], i),
            {28'd0, arr_wr_ok, arr_wr_blocked, sr_wr_ok, sr_wr_blocked},
            {28'd0, VEC[i][3:0]});
    end

    // R2 R3 R4 R5 sweep of codes, sizes and region edges
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 15; k++) begin
          logic p;
          p = model_prot(c[1:0], s[0], EDGES[k]);
          drive(c[1:0], s[0], EDGES[k], 4'b1111);
          check($sformatf("R2/R3/R4 sweep code %0d large %0d addr %h", c, s, EDGES[k]),
                {28'd0, arr_wr_ok, arr_wr_blocked, sr_wr_ok, sr_wr_blocked},
                {28'd0, ~p, p, 2'b10});
        end

    // R9 clear request follows the pin one cycle later
    drive(2'b00, 1'b1, 9'h000, 4'b0100);
    check("R9 not yet registered", {31'd0, wel_clr}, 32'd0);
    @(negedge clk); #2;
    check("R9 clear after pin low", {31'd0, wel_clr}, 32'd1);
    drive(2'b00, 1'b1, 9'h000, 4'b0110);
    check("R6 pin low refuses array", {30'd0, arr_wr_ok, arr_wr_blocked}, 32'd1);
    check("R9 clear held", {31'd0, wel_clr}, 32'd1);
    drive(2'b00, 1'b1, 9'h000, 4'b1100);
    @(negedge clk); #2;
    check("R9 clear drops after pin high", {31'd0, wel_clr}, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule